// File: doc/BRIEF.md
# Error Event Masking and Severity Classifier

This block sits between the error detectors of a serial-link endpoint and the logic that sends error messages upstream. Each cycle it can take one detected error event. An event carries a one-hot status vector, a flag that says whether the error is correctable, a flag that allows an uncorrectable nonfatal error to be reported as advisory, and a 16-bit requester ID. The block first drops any bit that is not a supported error. It then applies the mask and severity settings and the device reporting enables. From these it updates its correctable, uncorrectable and device status registers and decides whether to emit a message, and at which severity: correctable, nonfatal or fatal.

For an unmasked uncorrectable event, and for an advisory event whose original bit is unmasked, the block raises a request toward the header-log store in the same cycle. If that store answers that it is full, the block stalls its input for one cycle and processes a correctable header-log-overflow event of its own. The three status registers are cleared through a write-one-to-clear port.

Top module: `err_classifier`

## Requirements
- R1: An event is accepted when ev_valid and ev_ready are both high. The status vector is first ANDed with the supported set: 0x03FFF030 for uncorrectable events and 0x0000F1C1 for correctable ones. If the result is zero or has more than one bit set, the event is dropped: no status changes, no message and no log request.
- R2: A correctable event sets its bit in cor_status and sets dev_status[0]. It sends a correctable message only when its bit in cfg_cor_mask is clear and en_cor_rpt is set.
- R3: An uncorrectable event whose bit in cfg_unc_mask is set still sets its cor_status/unc_status and dev_status bits. It sends no message and raises no log request.
- R4: An uncorrectable event is fatal when its bit in cfg_unc_sev is 1, and nonfatal otherwise. A fatal event sets dev_status[2] and, when unmasked, sends a fatal message if en_syserr or en_fatal_rpt is set. A nonfatal event sets dev_status[1] and sends a nonfatal message if en_syserr or en_nf_rpt is set.
- R5: An unmasked uncorrectable event raises log_valid combinationally in its acceptance cycle, with log_bit equal to the filtered one-hot status and log_req_id equal to the event's ID.
- R6: A nonfatal event with ev_adv_ok set is handled as a correctable advisory error. It sets cor_status bit 13 and dev_status[0]. If cfg_cor_mask bit 13 is set, nothing else happens. Otherwise it sets its bit in unc_status, logs only when its unc mask bit is clear, and sends a correctable message when en_cor_rpt is set.
- R7: The unsupported-request error is uncorrectable bit 20. It also sets dev_status[3]. A correctable-class (advisory) message for it needs en_ur_rpt. An uncorrectable-class message for it is suppressed when en_ur_rpt and en_syserr are both clear.
- R8: When log_valid and log_ovf are high in the same cycle, ev_ready is low in the next cycle. In that cycle the block processes a correctable event with bit 15 and requester ID 0, following R2.
- R9: A message appears as a one-cycle msg_valid pulse in the cycle after acceptance. msg_sev is one-hot, with bit 0 for correctable, bit 1 for nonfatal and bit 2 for fatal, and msg_req_id carries the event's ID.
- R10: A write with wr_en clears every bit set in wr_data in the register chosen by wr_sel: 0 selects cor_status, 1 selects unc_status and 2 selects dev_status. A bit set by an event in the same cycle stays set.
- R11: After reset all status registers are zero, msg_valid is low and ev_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Error event present |
| ev_ready | output | 1 | Block can take an event this cycle |
| ev_status | input | 32 | One-hot error status bit of the event |
| ev_is_cor | input | 1 | Event is a correctable error |
| ev_adv_ok | input | 1 | Nonfatal event may be reported as advisory |
| ev_req_id | input | 16 | Requester ID of the event |
| cfg_unc_mask | input | 32 | Uncorrectable mask bits |
| cfg_unc_sev | input | 32 | Uncorrectable severity bits, 1 = fatal |
| cfg_cor_mask | input | 32 | Correctable mask bits |
| en_cor_rpt | input | 1 | Correctable reporting enable |
| en_nf_rpt | input | 1 | Nonfatal reporting enable |
| en_fatal_rpt | input | 1 | Fatal reporting enable |
| en_ur_rpt | input | 1 | Unsupported-request reporting enable |
| en_syserr | input | 1 | System-error enable |
| wr_en | input | 1 | Write-one-to-clear strobe |
| wr_sel | input | 2 | Target register of the clear |
| wr_data | input | 32 | Bits to clear |
| cor_status | output | 32 | Correctable status |
| unc_status | output | 32 | Uncorrectable status |
| dev_status | output | 4 | Detected flags: [0] cor, [1] nonfatal, [2] fatal, [3] UR |
| msg_valid | output | 1 | Message pulse |
| msg_sev | output | 3 | One-hot message severity |
| msg_req_id | output | 16 | Requester ID of the message |
| log_valid | output | 1 | Header-log request |
| log_bit | output | 32 | Status bit being logged |
| log_req_id | output | 16 | Requester ID being logged |
| log_ovf | input | 1 | Header-log store is full for the current request |

## Verification
Two functions can land in the same cycle. The first case is a clear write to cor_status in the cycle that a correctable event sets a bit in it. The bench drives both on one edge and expects only the event's bit to remain afterwards. The second case is the overflow follow-on event, which competes with the input stream. The bench holds log_ovf high during an unmasked nonfatal event and then checks three things in order: the original message, a cycle with ev_ready low, and a correctable message with ID 0 and cor_status bit 15.

// File: rtl/err_classifier_pkg.sv
package err_classifier_pkg;
    localparam int DEV_W     = 4;
    localparam int DEV_COR   = 0;
    localparam int DEV_NF    = 1;
    localparam int DEV_FATAL = 2;
    localparam int DEV_UR    = 3;

    localparam int SEV_W     = 3;
    localparam int SEV_COR   = 0;
    localparam int SEV_NF    = 1;
    localparam int SEV_FATAL = 2;

    typedef enum logic [1:0] {
        SEL_COR = 2'd0,
        SEL_UNC = 2'd1,
        SEL_DEV = 2'd2
    } clr_sel_e;
endpackage

// File: rtl/err_event_filter.sv
module err_event_filter #(
    parameter int                STAT_W  = 32,
    parameter logic [STAT_W-1:0] COR_SUP = 32'h0000_F1C1,
    parameter logic [STAT_W-1:0] UNC_SUP = 32'h03FF_F030
) (
    input  logic [STAT_W-1:0] raw_status,
    input  logic              is_cor,
    output logic [STAT_W-1:0] filt_status,
    output logic              single_bit
);
    always_comb begin
        filt_status = raw_status & (is_cor ? COR_SUP : UNC_SUP);
        single_bit  = (|filt_status) && ((filt_status & (filt_status - 1'b1)) == '0);
    end
endmodule

// File: rtl/err_severity_decide.sv
module err_severity_decide
    import err_classifier_pkg::*;
#(
    parameter int STAT_W  = 32,
    parameter int ADV_BIT = 13,
    parameter int UR_BIT  = 20
) (
    input  logic [STAT_W-1:0] st,
    input  logic              is_cor,
    input  logic              adv_ok,
    input  logic [STAT_W-1:0] unc_mask,
    input  logic [STAT_W-1:0] unc_sev,
    input  logic [STAT_W-1:0] cor_mask,
    input  logic              en_cor,
    input  logic              en_nf,
    input  logic              en_fatal,
    input  logic              en_ur,
    input  logic              en_serr,
    output logic [STAT_W-1:0] cor_set,
    output logic [STAT_W-1:0] unc_set,
    output logic [DEV_W-1:0]  dev_set,
    output logic [SEV_W-1:0]  sev,
    output logic              log_en
);
    logic is_ur, fatal, cor_hit, unc_hit, ur_block;

    always_comb begin
        is_ur    = !is_cor && st[UR_BIT];
        fatal    = |(st & unc_sev);
        cor_hit  = |(st & cor_mask);
        unc_hit  = |(st & unc_mask);
        ur_block = is_ur && !en_ur;
        cor_set  = '0;
        unc_set  = '0;
        dev_set  = '0;
        sev      = '0;
        log_en   = 1'b0;
        if (is_cor) begin
            cor_set          = st;
            dev_set[DEV_COR] = 1'b1;
            if (!cor_hit && en_cor) sev[SEV_COR] = 1'b1;
        end else if (!fatal && adv_ok) begin
            cor_set[ADV_BIT] = 1'b1;
            dev_set[DEV_COR] = 1'b1;
            dev_set[DEV_UR]  = is_ur;
            if (!cor_mask[ADV_BIT]) begin
                unc_set = st;
                log_en  = !unc_hit;
                if (en_cor && !ur_block) sev[SEV_COR] = 1'b1;
            end
        end else begin
            unc_set         = st;
            dev_set[DEV_UR] = is_ur;
            if (fatal) dev_set[DEV_FATAL] = 1'b1;
            else       dev_set[DEV_NF]    = 1'b1;
            if (!unc_hit) begin
                log_en = 1'b1;
                if (!(ur_block && !en_serr)) begin
                    if (fatal && (en_serr || en_fatal))      sev[SEV_FATAL] = 1'b1;
                    else if (!fatal && (en_serr || en_nf))   sev[SEV_NF]    = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/err_classifier.sv
module err_classifier
    import err_classifier_pkg::*;
#(
    parameter int                STAT_W  = 32,
    parameter int                RID_W   = 16,
    parameter int                ADV_BIT = 13,
    parameter int                HLO_BIT = 15,
    parameter int                UR_BIT  = 20,
    parameter logic [STAT_W-1:0] COR_SUP = 32'h0000_F1C1,
    parameter logic [STAT_W-1:0] UNC_SUP = 32'h03FF_F030
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    output logic              ev_ready,
    input  logic [STAT_W-1:0] ev_status,
    input  logic              ev_is_cor,
    input  logic              ev_adv_ok,
    input  logic [RID_W-1:0]  ev_req_id,
    input  logic [STAT_W-1:0] cfg_unc_mask,
    input  logic [STAT_W-1:0] cfg_unc_sev,
    input  logic [STAT_W-1:0] cfg_cor_mask,
    input  logic              en_cor_rpt,
    input  logic              en_nf_rpt,
    input  logic              en_fatal_rpt,
    input  logic              en_ur_rpt,
    input  logic              en_syserr,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [STAT_W-1:0] wr_data,
    output logic [STAT_W-1:0] cor_status,
    output logic [STAT_W-1:0] unc_status,
    output logic [DEV_W-1:0]  dev_status,
    output logic              msg_valid,
    output logic [SEV_W-1:0]  msg_sev,
    output logic [RID_W-1:0]  msg_req_id,
    output logic              log_valid,
    output logic [STAT_W-1:0] log_bit,
    output logic [RID_W-1:0]  log_req_id,
    input  logic              log_ovf
);
    localparam logic [STAT_W-1:0] HLO_VEC = STAT_W'(1) << HLO_BIT;

    typedef struct packed {
        logic [STAT_W-1:0] cor;
        logic [STAT_W-1:0] unc;
        logic [DEV_W-1:0]  dev;
        logic              mv;
        logic [SEV_W-1:0]  ms;
        logic [RID_W-1:0]  mr;
        logic              pend;
    } state_t;

    state_t st_d, st_q;

    logic [STAT_W-1:0] filt_st, cur_st, cor_set, unc_set;
    logic [STAT_W-1:0] clr_cor, clr_unc;
    logic [DEV_W-1:0]  dev_set, clr_dev;
    logic [SEV_W-1:0]  sev;
    logic [RID_W-1:0]  cur_rid;
    logic              single, cur_cor, cur_adv, take, log_en;

    err_event_filter #(
        .STAT_W (STAT_W),
        .COR_SUP(COR_SUP),
        .UNC_SUP(UNC_SUP)
    ) u_filter (
        .raw_status (ev_status),
        .is_cor     (ev_is_cor),
        .filt_status(filt_st),
        .single_bit (single)
    );

    always_comb begin
        if (st_q.pend) begin
            cur_st  = HLO_VEC;
            cur_cor = 1'b1;
            cur_adv = 1'b0;
            cur_rid = '0;
            take    = 1'b1;
        end else begin
            cur_st  = filt_st;
            cur_cor = ev_is_cor;
            cur_adv = ev_adv_ok;
            cur_rid = ev_req_id;
            take    = ev_valid && single;
        end
    end

    err_severity_decide #(
        .STAT_W (STAT_W),
        .ADV_BIT(ADV_BIT),
        .UR_BIT (UR_BIT)
    ) u_decide (
        .st      (cur_st),
        .is_cor  (cur_cor),
        .adv_ok  (cur_adv),
        .unc_mask(cfg_unc_mask),
        .unc_sev (cfg_unc_sev),
        .cor_mask(cfg_cor_mask),
        .en_cor  (en_cor_rpt),
        .en_nf   (en_nf_rpt),
        .en_fatal(en_fatal_rpt),
        .en_ur   (en_ur_rpt),
        .en_serr (en_syserr),
        .cor_set (cor_set),
        .unc_set (unc_set),
        .dev_set (dev_set),
        .sev     (sev),
        .log_en  (log_en)
    );

    always_comb begin
        ev_ready   = !st_q.pend;
        log_valid  = take && log_en;
        log_bit    = cur_st;
        log_req_id = cur_rid;
        clr_cor    = (wr_en && wr_sel == SEL_COR) ? wr_data : '0;
        clr_unc    = (wr_en && wr_sel == SEL_UNC) ? wr_data : '0;
        clr_dev    = (wr_en && wr_sel == SEL_DEV) ? wr_data[DEV_W-1:0] : '0;
        st_d       = st_q;
        st_d.cor   = (st_q.cor & ~clr_cor) | (take ? cor_set : '0);
        st_d.unc   = (st_q.unc & ~clr_unc) | (take ? unc_set : '0);
        st_d.dev   = (st_q.dev & ~clr_dev) | (take ? dev_set : '0);
        st_d.mv    = take && (|sev);
        st_d.ms    = take ? sev : '0;
        st_d.mr    = take ? cur_rid : st_q.mr;
        st_d.pend  = log_valid && log_ovf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cor_status = st_q.cor;
    assign unc_status = st_q.unc;
    assign dev_status = st_q.dev;
    assign msg_valid  = st_q.mv;
    assign msg_sev    = st_q.ms;
    assign msg_req_id = st_q.mr;
endmodule

// File: rtl/err_classifier_chk.sv
module err_classifier_chk #(
    parameter int                STAT_W  = 32,
    parameter logic [STAT_W-1:0] UNC_SUP = 32'h03FF_F030,
    parameter logic [STAT_W-1:0] COR_SUP = 32'h0000_F1C1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_valid,
    input logic              ev_ready,
    input logic [STAT_W-1:0] ev_status,
    input logic              ev_is_cor,
    input logic [STAT_W-1:0] cfg_unc_mask,
    input logic              msg_valid,
    input logic [2:0]        msg_sev,
    input logic              log_valid,
    input logic [STAT_W-1:0] log_bit,
    input logic              log_ovf
);
    logic [STAT_W-1:0] chk_filt;
    assign chk_filt = ev_status & (ev_is_cor ? COR_SUP : UNC_SUP);

    p_drop_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_ready && chk_filt == '0) |=> !msg_valid);

    p_masked_nolog_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_ready && !ev_is_cor && |(ev_status & UNC_SUP & cfg_unc_mask)) |-> !log_valid);

    p_log_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        log_valid |-> $onehot(log_bit));

    p_ovf_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (log_valid && log_ovf) |=> !ev_ready);

    p_sev_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> $onehot(msg_sev));

    p_idle_nosev_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_valid |-> (msg_sev == 3'b000));
endmodule

bind err_classifier err_classifier_chk #(
    .STAT_W (STAT_W),
    .UNC_SUP(UNC_SUP),
    .COR_SUP(COR_SUP)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_valid    (ev_valid),
    .ev_ready    (ev_ready),
    .ev_status   (ev_status),
    .ev_is_cor   (ev_is_cor),
    .cfg_unc_mask(cfg_unc_mask),
    .msg_valid   (msg_valid),
    .msg_sev     (msg_sev),
    .log_valid   (log_valid),
    .log_bit     (log_bit),
    .log_ovf     (log_ovf)
);

// File: tb/err_classifier_bench.sv
`timescale 1ns/1ps
module err_classifier_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_valid = 1'b0;
    logic        ev_ready;
    logic [31:0] ev_status = '0;
    logic        ev_is_cor = 1'b0;
    logic        ev_adv_ok = 1'b0;
    logic [15:0] ev_req_id = '0;
    logic [31:0] cfg_unc_mask = '0, cfg_unc_sev = '0, cfg_cor_mask = '0;
    logic        en_cor_rpt = 0, en_nf_rpt = 0, en_fatal_rpt = 0, en_ur_rpt = 0, en_syserr = 0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] cor_status, unc_status;
    logic [3:0]  dev_status;
    logic        msg_valid;
    logic [2:0]  msg_sev;
    logic [15:0] msg_req_id;
    logic        log_valid;
    logic [31:0] log_bit;
    logic [15:0] log_req_id;
    logic        log_ovf = 1'b0;

    int checks = 0, failures = 0;
    logic        seen_log;
    logic [31:0] seen_bit;
    logic [15:0] seen_rid;

    always #4 clk = ~clk;

    err_classifier u_err_classifier (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
        .ev_status(ev_status), .ev_is_cor(ev_is_cor), .ev_adv_ok(ev_adv_ok),
        .ev_req_id(ev_req_id), .cfg_unc_mask(cfg_unc_mask), .cfg_unc_sev(cfg_unc_sev),
        .cfg_cor_mask(cfg_cor_mask), .en_cor_rpt(en_cor_rpt), .en_nf_rpt(en_nf_rpt),
        .en_fatal_rpt(en_fatal_rpt), .en_ur_rpt(en_ur_rpt), .en_syserr(en_syserr),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .cor_status(cor_status),
        .unc_status(unc_status), .dev_status(dev_status), .msg_valid(msg_valid),
        .msg_sev(msg_sev), .msg_req_id(msg_req_id), .log_valid(log_valid),
        .log_bit(log_bit), .log_req_id(log_req_id), .log_ovf(log_ovf)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] st, input logic cor, input logic adv, input logic [15:0] rid);
        @(negedge clk);
        ev_status = st; ev_is_cor = cor; ev_adv_ok = adv; ev_req_id = rid; ev_valid = 1'b1;
        #1;
        seen_log = log_valid; seen_bit = log_bit; seen_rid = log_req_id;
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reset_cfg();
        cfg_unc_mask = '0; cfg_unc_sev = '0; cfg_cor_mask = '0;
        en_cor_rpt = 0; en_nf_rpt = 0; en_fatal_rpt = 0; en_ur_rpt = 0; en_syserr = 0;
        log_ovf = 0;
        wr(2'd0, '1); wr(2'd1, '1); wr(2'd2, '1);
    endtask

    task automatic t_reset();
        chk("R11", "ev_ready", 32'(ev_ready), 32'h1);
        chk("R11", "cor_status", cor_status, 32'h0);
        chk("R11", "unc_status", unc_status, 32'h0);
        chk("R11", "dev_status", 32'(dev_status), 32'h0);
        chk("R11", "msg_valid", 32'(msg_valid), 32'h0);
    endtask

    task automatic t_reject();
        reset_cfg();
        en_nf_rpt = 1; en_fatal_rpt = 1; en_cor_rpt = 1;
        send(32'h0000_0030, 1'b0, 1'b0, 16'h0101);
        chk("R1", "two bits log", 32'(seen_log), 32'h0);
        chk("R1", "two bits msg", 32'(msg_valid), 32'h0);
        chk("R1", "two bits unc", unc_status, 32'h0);
        send(32'h0000_0001, 1'b0, 1'b0, 16'h0102);
        chk("R1", "unsupported unc", unc_status, 32'h0);
        chk("R1", "unsupported dev", 32'(dev_status), 32'h0);
        send(32'h0000_0002, 1'b1, 1'b0, 16'h0103);
        chk("R1", "unsupported cor", cor_status, 32'h0);
        chk("R1", "unsupported cor msg", 32'(msg_valid), 32'h0);
    endtask

    task automatic t_cor();
        reset_cfg();
        en_cor_rpt = 1;
        send(32'h0000_0040, 1'b1, 1'b0, 16'h1234);
        chk("R2", "cor msg valid", 32'(msg_valid), 32'h1);
        chk("R9", "cor msg sev", 32'(msg_sev), 32'h1);
        chk("R9", "cor msg rid", 32'(msg_req_id), 32'h1234);
        chk("R2", "cor status", cor_status, 32'h40);
        chk("R2", "cor dev", 32'(dev_status), 32'h1);
        chk("R2", "cor no log", 32'(seen_log), 32'h0);
        @(negedge clk);
        chk("R9", "msg one cycle", 32'(msg_valid), 32'h0);
        cfg_cor_mask = 32'h80;
        send(32'h0000_0080, 1'b1, 1'b0, 16'h2);
        chk("R2", "masked cor msg", 32'(msg_valid), 32'h0);
        chk("R2", "masked cor status", cor_status, 32'hC0);
        cfg_cor_mask = '0; en_cor_rpt = 0;
        send(32'h0000_0001, 1'b1, 1'b0, 16'h3);
        chk("R2", "disabled cor msg", 32'(msg_valid), 32'h0);
        chk("R2", "disabled cor status", cor_status, 32'hC1);
    endtask

    task automatic t_severity();
        reset_cfg();
        cfg_unc_sev = 32'h10; en_fatal_rpt = 1;
        send(32'h0000_0010, 1'b0, 1'b0, 16'hA5A5);
        chk("R5", "fatal log", 32'(seen_log), 32'h1);
        chk("R5", "fatal log bit", seen_bit, 32'h10);
        chk("R5", "fatal log rid", 32'(seen_rid), 32'hA5A5);
        chk("R4", "fatal sev", 32'(msg_sev), 32'h4);
        chk("R4", "fatal dev", 32'(dev_status), 32'h4);
        chk("R4", "fatal unc", unc_status, 32'h10);
        reset_cfg();
        send(32'h0000_1000, 1'b0, 1'b0, 16'h7);
        chk("R4", "nf no enable msg", 32'(msg_valid), 32'h0);
        chk("R4", "nf dev", 32'(dev_status), 32'h2);
        chk("R5", "nf log", 32'(seen_log), 32'h1);
        en_syserr = 1;
        send(32'h0000_1000, 1'b0, 1'b0, 16'h8);
        chk("R4", "nf via syserr", 32'(msg_sev), 32'h2);
        chk("R9", "nf valid", 32'(msg_valid), 32'h1);
    endtask

    task automatic t_masked();
        reset_cfg();
        en_nf_rpt = 1; en_syserr = 1; cfg_unc_mask = 32'h4000;
        send(32'h0000_4000, 1'b0, 1'b0, 16'h9);
        chk("R3", "masked log", 32'(seen_log), 32'h0);
        chk("R3", "masked msg", 32'(msg_valid), 32'h0);
        chk("R3", "masked unc", unc_status, 32'h4000);
        chk("R3", "masked dev", 32'(dev_status), 32'h2);
    endtask

    task automatic t_advisory();
        reset_cfg();
        en_cor_rpt = 1;
        send(32'h0001_0000, 1'b0, 1'b1, 16'h55);
        chk("R6", "adv cor", cor_status, 32'h2000);
        chk("R6", "adv unc", unc_status, 32'h10000);
        chk("R6", "adv log", 32'(seen_log), 32'h1);
        chk("R6", "adv sev", 32'(msg_sev), 32'h1);
        chk("R6", "adv dev", 32'(dev_status), 32'h1);
        reset_cfg();
        en_cor_rpt = 1; cfg_unc_mask = 32'h10000;
        send(32'h0001_0000, 1'b0, 1'b1, 16'h56);
        chk("R6", "adv masked log", 32'(seen_log), 32'h0);
        chk("R6", "adv masked sev", 32'(msg_sev), 32'h1);
        chk("R6", "adv masked unc", unc_status, 32'h10000);
        reset_cfg();
        en_cor_rpt = 1; cfg_cor_mask = 32'h2000;
        send(32'h0001_0000, 1'b0, 1'b1, 16'h57);
        chk("R6", "adv cormask cor", cor_status, 32'h2000);
        chk("R6", "adv cormask unc", unc_status, 32'h0);
        chk("R6", "adv cormask msg", 32'(msg_valid), 32'h0);
        chk("R6", "adv cormask log", 32'(seen_log), 32'h0);
    endtask

    task automatic t_ur();
        reset_cfg();
        en_nf_rpt = 1;
        send(32'h0010_0000, 1'b0, 1'b0, 16'h20);
        chk("R7", "ur gated msg", 32'(msg_valid), 32'h0);
        chk("R7", "ur dev", 32'(dev_status), 32'hA);
        en_ur_rpt = 1;
        send(32'h0010_0000, 1'b0, 1'b0, 16'h21);
        chk("R7", "ur enabled sev", 32'(msg_sev), 32'h2);
        en_ur_rpt = 0; en_nf_rpt = 0; en_syserr = 1;
        send(32'h0010_0000, 1'b0, 1'b0, 16'h22);
        chk("R7", "ur syserr sev", 32'(msg_sev), 32'h2);
        reset_cfg();
        en_cor_rpt = 1; en_syserr = 1;
        send(32'h0010_0000, 1'b0, 1'b1, 16'h23);
        chk("R7", "ur adv gated", 32'(msg_valid), 32'h0);
        chk("R7", "ur adv dev", 32'(dev_status), 32'h9);
        en_ur_rpt = 1;
        send(32'h0010_0000, 1'b0, 1'b1, 16'h24);
        chk("R7", "ur adv enabled sev", 32'(msg_sev), 32'h1);
    endtask

    task automatic t_overflow();
        reset_cfg();
        en_nf_rpt = 1; en_cor_rpt = 1; log_ovf = 1;
        send(32'h0002_0000, 1'b0, 1'b0, 16'hBEEF);
        log_ovf = 0;
        chk("R8", "orig log", 32'(seen_log), 32'h1);
        chk("R8", "orig sev", 32'(msg_sev), 32'h2);
        chk("R8", "orig rid", 32'(msg_req_id), 32'hBEEF);
        chk("R8", "stall ready", 32'(ev_ready), 32'h0);
        @(negedge clk);
        chk("R8", "hlo sev", 32'(msg_sev), 32'h1);
        chk("R8", "hlo rid", 32'(msg_req_id), 32'h0);
        chk("R8", "hlo cor", cor_status, 32'h8000);
        chk("R8", "ready back", 32'(ev_ready), 32'h1);
    endtask

    task automatic t_w1c();
        reset_cfg();
        send(32'h0000_0040, 1'b1, 1'b0, 16'h1);
        send(32'h0000_0020, 1'b0, 1'b0, 16'h2);
        wr(2'd1, 32'h0000_0020);
        chk("R10", "unc cleared", unc_status, 32'h0);
        chk("R10", "cor untouched", cor_status, 32'h40);
        wr(2'd2, 32'h0000_0002);
        chk("R10", "dev partial clear", 32'(dev_status), 32'h1);
        @(negedge clk);
        ev_status = 32'h1; ev_is_cor = 1; ev_adv_ok = 0; ev_valid = 1;
        wr_en = 1; wr_sel = 2'd0; wr_data = '1;
        @(negedge clk);
        ev_valid = 0; wr_en = 0;
        chk("R10", "set wins over clear", cor_status, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reject();
        t_cor();
        t_severity();
        t_masked();
        t_advisory();
        t_ur();
        t_overflow();
        t_w1c();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #800000;
        checks++;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule